// File: doc/BRIEF.md
# Root Port Interrupt Event Queue

This block collects interrupt events that arrive at a PCIe root port and holds them in order until software services them. Two kinds of event arrive: a legacy line assertion (one of four lines, A to D) and an inbound memory write that carries a message-signalled interrupt. Both kinds share a single first-in first-out queue. An inbound write counts as a message interrupt only when its full 64-bit address equals the target address held in two software-visible base registers. Any other inbound write leaves the queue untouched.

Software sees the oldest entry through a pair of 32-bit read registers. The first register tells whether an entry is present and what kind it is, and for a line event it also carries the line number. The second register carries the 16-bit message data of a message event. Both registers always show the same entry. A write of any value to the first register retires that entry. On every accepted event the block pulses a decode event bit toward the port's interrupt decode logic. The bit it pulses depends on the kind of event. When the queue is full, further events are discarded and a sticky overflow flag is raised.

Top module: `rp_intr_fifo`

## Requirements
- R1: After a synchronous active-low reset the queue is empty, all four registers read zero, `evt_bits` is zero and `overflow` is low.
- R2: An accepted line event makes the head register at offset 0x158 read bit 31 = 1, bit 30 = 0 and the line number (0..3) in bits 28:27. The data register at offset 0x15C then reads zero.
- R3: An inbound write is queued only when `msi_addr` equals {register 0x14C, register 0x150}. With any other address it changes neither the queue nor `evt_bits`.
- R4: An accepted message event makes offset 0x158 read bit 31 = 1 and bit 30 = 1, with bits 28:27 at zero. Offset 0x15C reads the message data in bits 15:0.
- R5: A register write to offset 0x158 retires the head entry, whatever value is written. Both read registers then show the next entry together. A retire on an empty queue has no effect.
- R6: One cycle after an event is accepted, `evt_bits` pulses for one cycle: bit 16 for a line event and bit 17 for a message event. A dropped event pulses nothing.
- R7: Entries leave in arrival order. When a line event and a matching message write arrive in the same cycle, the line event is queued first.
- R8: When there is no room, an arriving event is dropped, the entries already held are kept, and `overflow` goes high and stays high until reset. With one free slot and two simultaneous events, the line event is kept and the message event is dropped.
- R9: While the queue is empty, offsets 0x158 and 0x15C read zero.
- R10: Offsets 0x14C (upper address half) and 0x150 (lower address half) are read/write registers. They change only when written at their own offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | REG_AW | Register byte offset for reads and writes |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data at `reg_addr` |
| intx_valid | input | 1 | Legacy line assertion event |
| intx_line | input | 2 | Line number of the event (0=A .. 3=D) |
| msi_valid | input | 1 | Inbound memory write |
| msi_addr | input | 64 | Address of the inbound write |
| msi_data | input | 16 | Message data of the inbound write |
| evt_bits | output | 32 | Decode event pulses (bit 16 line, bit 17 message) |
| overflow | output | 1 | Sticky: an event was dropped |

## Verification
The bench builds the block with DEPTH = 4, so the full queue, the drop of a single event and the split case where a simultaneous pair meets one free slot are all reached with a handful of pushes. The register offset width stays at its default of 12 bits, so the real offsets are decoded. A scoreboard queue predicts every head entry as it is drained, including after retires on an empty queue and retires written with a value other than all ones.

// File: rtl/rp_evt_pkg.sv
// Package: shared register offsets, field positions and the queue entry type
// for the root port interrupt event queue.
// Assumes: register offsets are byte offsets no wider than 12 bits.
package rp_evt_pkg;

    localparam logic [11:0] OFS_BASE_HI = 12'h14C;
    localparam logic [11:0] OFS_BASE_LO = 12'h150;
    localparam logic [11:0] OFS_HEAD    = 12'h158;
    localparam logic [11:0] OFS_DATA    = 12'h15C;

    localparam int HEAD_VALID_BIT = 31;
    localparam int HEAD_KIND_BIT  = 30;
    localparam int HEAD_LINE_LSB  = 27;
    localparam int EVT_LINE_BIT   = 16;
    localparam int EVT_MSG_BIT    = 17;

    localparam int MSG_DATA_W = 16;

    typedef struct packed {
        logic                  is_msg;
        logic [1:0]            line;
        logic [MSG_DATA_W-1:0] data;
    } evt_entry_t;

endpackage

// File: rtl/rp_evt_fifo.sv
// Module: rp_evt_fifo
// Ordered event store with two push ports per cycle (port A is written ahead
// of port B) and one retire port. A push that finds no room is refused.
// Assumes: DEPTH >= 2. Room is judged on the occupancy before this cycle's
// retire, so a retire never makes room for a push in the same cycle.
module rp_evt_fifo
    import rp_evt_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_a,
    input  evt_entry_t ent_a,
    input  logic       push_b,
    input  evt_entry_t ent_b,
    input  logic       pop,
    output logic       acc_a,
    output logic       acc_b,
    output evt_entry_t head,
    output logic       not_empty,
    output logic       is_full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    evt_entry_t        mem [DEPTH];
    logic [PTR_W-1:0]  wp_q, rp_q, wb_idx;
    logic [CNT_W-1:0]  cnt_q, free_slots;
    logic              do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Decide which pushes fit and where port B lands.
    always_comb begin
        free_slots = CNT_W'(DEPTH) - cnt_q;
        acc_a      = push_a && (free_slots != '0);
        acc_b      = push_b && (acc_a ? (free_slots >= CNT_W'(2)) : (free_slots != '0));
        do_pop     = pop && (cnt_q != '0);
        wb_idx     = acc_a ? bump(wp_q) : wp_q;
    end

    // Storage writes; contents need no reset because occupancy guards them.
    always_ff @(posedge clk) begin
        if (acc_a) mem[wp_q]   <= ent_a;
        if (acc_b) mem[wb_idx] <= ent_b;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (acc_a && acc_b)      wp_q <= bump(bump(wp_q));
            else if (acc_a || acc_b) wp_q <= bump(wp_q);
            if (do_pop)              rp_q <= bump(rp_q);
            cnt_q <= cnt_q + CNT_W'(acc_a) + CNT_W'(acc_b) - CNT_W'(do_pop);
        end
    end

    assign head      = mem[rp_q];
    assign not_empty = (cnt_q != '0);
    assign is_full   = (cnt_q == CNT_W'(DEPTH));

    // R8: occupancy never exceeds the depth.
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

    // R8: a full queue stays full until something is retired.
    a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && !pop) |=> is_full);

    // R5: a retire on an empty queue leaves it empty when nothing arrives.
    a_r5_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (!not_empty && !push_a && !push_b) |=> !not_empty);

endmodule

// File: rtl/rp_msi_window.sv
// Module: rp_msi_window
// Holds the two halves of the message interrupt target address and flags an
// inbound write whose full address matches them.
// Assumes: register writes and inbound writes are single-cycle strobes.
module rp_msi_window
    import rp_evt_pkg::*;
#(
    parameter int REG_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              in_valid,
    input  logic [63:0]       in_addr,
    output logic [31:0]       base_hi,
    output logic [31:0]       base_lo,
    output logic              hit
);
    logic wr_hi, wr_lo;

    assign wr_hi = cfg_wr && (cfg_addr == REG_AW'(OFS_BASE_HI));
    assign wr_lo = cfg_wr && (cfg_addr == REG_AW'(OFS_BASE_LO));

    // Target address registers, written only at their own offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hi <= '0;
            base_lo <= '0;
        end else begin
            if (wr_hi) base_hi <= cfg_wdata;
            if (wr_lo) base_lo <= cfg_wdata;
        end
    end

    // Full 64-bit comparison of the inbound address.
    assign hit = in_valid && (in_addr == {base_hi, base_lo});

    // R10: the upper half changes only on a write at its offset.
    a_r10_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && cfg_addr == REG_AW'(OFS_BASE_HI)) |=> $stable(base_hi));

    // R10: the lower half changes only on a write at its offset.
    a_r10_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && cfg_addr == REG_AW'(OFS_BASE_LO)) |=> $stable(base_lo));

endmodule

// File: rtl/rp_reg_read.sv
// Module: rp_reg_read
// Combinational read mux: formats the head entry into the two head registers
// and returns the address halves. Unmapped offsets read zero.
// Assumes: the head entry is meaningful only while not_empty is high.
module rp_reg_read
    import rp_evt_pkg::*;
#(
    parameter int REG_AW = 12
) (
    input  logic [REG_AW-1:0] addr,
    input  evt_entry_t        head,
    input  logic              not_empty,
    input  logic [31:0]       base_hi,
    input  logic [31:0]       base_lo,
    output logic [31:0]       rdata
);
    logic [31:0] head_w, data_w;

    // Build the two views of the head entry.
    always_comb begin
        head_w = '0;
        data_w = '0;
        if (not_empty) begin
            head_w[HEAD_VALID_BIT] = 1'b1;
            head_w[HEAD_KIND_BIT]  = head.is_msg;
            if (!head.is_msg) head_w[HEAD_LINE_LSB +: 2] = head.line;
            else              data_w[MSG_DATA_W-1:0]     = head.data;
        end
    end

    // Select by offset.
    always_comb begin
        unique case (addr)
            REG_AW'(OFS_HEAD):    rdata = head_w;
            REG_AW'(OFS_DATA):    rdata = data_w;
            REG_AW'(OFS_BASE_HI): rdata = base_hi;
            REG_AW'(OFS_BASE_LO): rdata = base_lo;
            default:              rdata = '0;
        endcase
    end

endmodule

// File: rtl/rp_intr_fifo.sv
// Module: rp_intr_fifo (top)
// Root port interrupt event queue: queues line events and address-matched
// message writes, exposes the head through two registers, retires on a write
// to the head register, pulses decode event bits and flags drops.
// Assumes: synchronous active-low reset; one register access per cycle.
module rp_intr_fifo
    import rp_evt_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int REG_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              intx_valid,
    input  logic [1:0]        intx_line,
    input  logic              msi_valid,
    input  logic [63:0]       msi_addr,
    input  logic [MSG_DATA_W-1:0] msi_data,
    output logic [31:0]       evt_bits,
    output logic              overflow
);
    evt_entry_t  ent_line, ent_msg, head;
    logic        msg_hit, acc_line, acc_msg, not_empty, is_full, retire;
    logic [31:0] base_hi, base_lo;
    logic [31:0] evt_q;
    logic        ovf_q;

    assign retire   = reg_wr && (reg_addr == REG_AW'(OFS_HEAD));
    assign ent_line = '{is_msg: 1'b0, line: intx_line, data: '0};
    assign ent_msg  = '{is_msg: 1'b1, line: 2'b00,     data: msi_data};

    rp_msi_window #(.REG_AW(REG_AW)) u_win (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(reg_wr), .cfg_addr(reg_addr), .cfg_wdata(reg_wdata),
        .in_valid(msi_valid), .in_addr(msi_addr),
        .base_hi(base_hi), .base_lo(base_lo), .hit(msg_hit)
    );

    rp_evt_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_a(intx_valid), .ent_a(ent_line),
        .push_b(msg_hit),    .ent_b(ent_msg),
        .pop(retire),
        .acc_a(acc_line), .acc_b(acc_msg),
        .head(head), .not_empty(not_empty), .is_full(is_full)
    );

    rp_reg_read #(.REG_AW(REG_AW)) u_rd (
        .addr(reg_addr), .head(head), .not_empty(not_empty),
        .base_hi(base_hi), .base_lo(base_lo), .rdata(reg_rdata)
    );

    // Decode event pulses and the sticky drop flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            evt_q              <= '0;
            evt_q[EVT_LINE_BIT] <= acc_line;
            evt_q[EVT_MSG_BIT]  <= acc_msg;
            ovf_q <= ovf_q | (intx_valid & ~acc_line) | (msg_hit & ~acc_msg);
        end
    end

    assign evt_bits = evt_q;
    assign overflow = ovf_q;

    // R8: the drop flag never falls outside reset.
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);

    // R6: an event pulse always has a queued entry behind it.
    a_r6_evt_has_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q[EVT_LINE_BIT] || evt_q[EVT_MSG_BIT]) |-> not_empty);

    // R8: a drop can happen only with the queue at most one slot from full.
    a_r8_drop_near_full: assert property (@(posedge clk) disable iff (!rst_n)
        ((intx_valid && !acc_line) || (msg_hit && !acc_msg)) |-> (is_full || (intx_valid && msg_hit)));

endmodule

// File: tb/tb_rp_intr_fifo.sv
// Scoreboard bench: driver tasks push predicted entries into a queue, the
// drain task retires entries and compares each head against the queue front.
module tb_rp_intr_fifo;
    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        intx_valid = 1'b0;
    logic [1:0]  intx_line = '0;
    logic        msi_valid = 1'b0;
    logic [63:0] msi_addr = '0;
    logic [15:0] msi_data = '0;
    logic [31:0] evt_bits;
    logic        overflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [18:0] sb[$];          // {is_msg, line, data}
    logic        exp_ovf = 1'b0;

    localparam logic [63:0] TARGET = 64'h0000_0001_FEE0_0000;

    always #2.5 clk = ~clk;      // 200 MHz

    rp_intr_fifo #(.DEPTH(D), .REG_AW(12)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .intx_valid(intx_valid),
        .intx_line(intx_line), .msi_valid(msi_valid), .msi_addr(msi_addr),
        .msi_data(msi_data), .evt_bits(evt_bits), .overflow(overflow)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Driver: apply one cycle of events, predict acceptance, check pulses.
    task automatic drive(input string req, input bit ln, input logic [1:0] l,
                         input bit mg, input logic [63:0] a, input logic [15:0] d);
        logic [31:0] exp_evt;
        bit hit;
        exp_evt = '0;
        hit = mg && (a == TARGET);
        @(negedge clk);
        intx_valid = ln; intx_line = l; msi_valid = mg; msi_addr = a; msi_data = d;
        if (ln) begin
            if (sb.size() < D) begin sb.push_back({1'b0, l, 16'h0}); exp_evt[16] = 1'b1; end
            else exp_ovf = 1'b1;
        end
        if (hit) begin
            if (sb.size() < D) begin sb.push_back({1'b1, 2'b00, d}); exp_evt[17] = 1'b1; end
            else exp_ovf = 1'b1;
        end
        @(negedge clk);
        intx_valid = 1'b0; msi_valid = 1'b0;
        check({req, " evt"}, evt_bits, exp_evt);
        check({req, " ovf"}, {31'b0, overflow}, {31'b0, exp_ovf});
    endtask

    // Monitor: compare the head registers against the scoreboard front.
    task automatic chk_head(input string req);
        logic [31:0] w0, w1, e0, e1;
        logic [18:0] f;
        e0 = '0; e1 = '0;
        if (sb.size() != 0) begin
            f = sb[0];
            e0[31] = 1'b1;
            e0[30] = f[18];
            if (!f[18]) e0[28:27] = f[17:16];
            else        e1[15:0]  = f[15:0];
        end
        rd(12'h158, w0);
        rd(12'h15C, w1);
        check({req, " head"}, w0, e0);
        check({req, " data"}, w1, e1);
    endtask

    task automatic drain_one(input string req, input logic [31:0] v);
        chk_head(req);
        wr(12'h158, v);
        if (sb.size() != 0) void'(sb.pop_front());
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                fails++; checks++;
                $display("FAIL watchdog actual=%0d expected<=20000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd(12'h158, v); check("R1 head", v, 0);
        rd(12'h15C, v); check("R1 data", v, 0);
        rd(12'h14C, v); check("R1 hi", v, 0);
        rd(12'h150, v); check("R1 lo", v, 0);
        check("R1 evt", evt_bits, 0);
        check("R1 ovf", {31'b0, overflow}, 0);

        // R10: address registers
        wr(12'h14C, TARGET[63:32]);
        wr(12'h150, TARGET[31:0]);
        wr(12'h154, 32'hDEAD_BEEF);
        rd(12'h14C, v); check("R10 hi", v, TARGET[63:32]);
        rd(12'h150, v); check("R10 lo", v, TARGET[31:0]);

        // R2 R6: line event
        drive("R6 line", 1, 2'd2, 0, 64'h0, 16'h0);
        chk_head("R2");
        drain_one("R5 retire", 32'hFFFF_FFFF);
        chk_head("R9 empty");

        // R3: mismatched addresses ignored
        drive("R3 wrong lo", 0, 0, 1, TARGET ^ 64'h10, 16'h12);
        drive("R3 wrong hi", 0, 0, 1, TARGET ^ 64'h1_0000_0000, 16'h13);
        chk_head("R3 still empty");

        // R4 R6: matching message
        drive("R6 msg", 0, 0, 1, TARGET, 16'h007F);
        chk_head("R4");
        drain_one("R5 retire msg", 32'h0);
        // R5: retire on empty, then one entry in and out
        wr(12'h158, 32'hFFFF_FFFF);
        chk_head("R5 empty pop");
        drive("R5 after empty pop", 1, 2'd1, 0, 64'h0, 16'h0);
        drain_one("R5 single", 32'h1234_5678);
        chk_head("R9 empty again");

        // R7: simultaneous pair, line first
        drive("R7 pair", 1, 2'd3, 1, TARGET, 16'h0005);
        drive("R7 msg2", 0, 0, 1, TARGET, 16'hABCD);
        drive("R7 line0", 1, 2'd0, 0, 64'h0, 16'h0);
        // R8: full, drop a line event
        drive("R8 drop line", 1, 2'd1, 0, 64'h0, 16'h0);
        while (sb.size() != 0) drain_one("R7 order", 32'hFFFF_FFFF);
        chk_head("R8 drained");

        // R8: one slot free, pair arrives -> line kept, message dropped
        drive("R8 fill1", 1, 2'd0, 0, 64'h0, 16'h0);
        drive("R8 fill2", 0, 0, 1, TARGET, 16'h0011);
        drive("R8 fill3", 1, 2'd2, 0, 64'h0, 16'h0);
        drive("R8 split", 1, 2'd3, 1, TARGET, 16'h0022);
        drive("R8 full msg", 0, 0, 1, TARGET, 16'h0033);
        while (sb.size() != 0) drain_one("R8 kept", 32'hFFFF_FFFF);
        chk_head("R8 final empty");
        check("R8 sticky", {31'b0, overflow}, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule